// File: doc/BRIEF.md
# Cache Parameter Tuning Controller

This block sits beside a configurable cache. It estimates the memory energy of the cache configuration that is currently applied, and uses that estimate to choose a low-energy configuration. The estimate is formed in hardware from hit pulses, miss pulses and a cycle tick, all weighted by programmable constants. A start command launches a greedy search that tunes one parameter at a time in a fixed priority: total size first, then line size, then associativity, and finally way prediction. When the search ends, the best configuration found stays applied and a done flag is raised.

Every time the configuration changes, the block requests a cache flush and waits for an acknowledge. It then measures energy over a programmable window of ticks and compares the result with the best energy seen so far. A parameter keeps moving to its next larger value only while the energy strictly improves. As soon as it does not improve, the parameter falls back to its best value and the next parameter is tuned. The search therefore visits a number of configurations bounded by the sum of the value counts of the parameters, not by their product.

The controller has five states:
- IDLE: the state after reset.
- FLUSH: raises the flush request and waits for the acknowledge.
- MEASURE: accumulates energy until the window of ticks ends.
- DECIDE: compares the measured energy with the best so far, then either steps the current parameter, opens the next phase, or finishes.
- DONE: holds the result.

Its transitions are:
- start moves IDLE or DONE to FLUSH.
- The acknowledge moves FLUSH to MEASURE, or to DONE when the flush belongs to the final application of the result.
- The end of the window moves MEASURE to DECIDE.
- DECIDE moves to FLUSH or to DONE.

Top module: `cache_tune_ctrl`

## Requirements
- R1: After reset, done and the flush request are low and the configuration outputs show the initial configuration. The encodings are: size_sel 0/1/2 = 2/4/8 KB, line_sel 0/1/2 = 16/32/64 bytes, assoc_sel 0/1/2 = 1/2/4 ways, and wpred_en 0 = off. The initial configuration is all fields 0, and the value 3 never appears on any field.
- R2: A start command received in IDLE or DONE restarts the search from the initial configuration. In the next cycle done is low and the flush request is high.
- R3: Each configuration that is applied raises flush_req_o, which stays high until flush_done_i is seen. The measurement starts in the following cycle, and the configuration does not change from the request until the window ends.
- R4: The measured energy is the sum, over the window, of e_hit for each hit cycle, k_miss×e_hit for each miss cycle and e_static for each tick. The sum is accumulated in 48 bits and saturates. The window ends on the window_i-th tick, and that cycle's events are included; a window of 0 acts as 1.
- R5: The parameters are tuned in the order size, line, assoc, way prediction, and each moves upward from its current best value one code at a time.
- R6: A parameter advances only while the energy strictly improves on the best so far. An equal or worse result ends that parameter and restores its best value.
- R7: Way prediction is tried only if the chosen associativity is more than one way, and wpred_en is never high while assoc_sel is 0.
- R8: A run measures at most 8 windows. One extra flush, with no measurement, applies the result when it differs from the last measured configuration.
- R9: done stays high and the configuration outputs stay constant until the next start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a tuning run (used in IDLE or DONE) |
| hit_i | input | 1 | Cache hit in this cycle |
| miss_i | input | 1 | Cache miss in this cycle |
| tick_i | input | 1 | Cycle tick for static energy and window |
| e_hit_i | input | 16 | Energy per hit |
| k_miss_i | input | 16 | Miss-to-hit energy ratio |
| e_static_i | input | 16 | Static energy per tick |
| window_i | input | 16 | Measurement window length in ticks |
| flush_done_i | input | 1 | Flush acknowledge |
| flush_req_o | output | 1 | Flush request, held until acknowledged |
| size_sel_o | output | 2 | Total size code |
| line_sel_o | output | 2 | Line size code |
| assoc_sel_o | output | 2 | Associativity code |
| wpred_en_o | output | 1 | Way prediction enable |
| done_o | output | 1 | Search finished, result applied |

## Verification
The assertions check the following on every cycle:
- the flush request is held until it is acknowledged;
- the configuration stays frozen during a measurement;
- way prediction is never enabled with a direct-mapped setting;
- no illegal field code appears;
- the energy accumulator never decreases within a window, so it cannot wrap;
- the result is held while done is high.

The search outcome can only be shown by the directed scenarios: the final configuration, the number of flushes, the strict-improvement rule on ties, and the effect of k_miss on which configuration wins. The bench shapes the miss pattern per configuration so that each scenario has a known winner.

// File: rtl/tune_pkg.sv
package tune_pkg;
    localparam int          SEL_W    = 2;
    localparam logic [1:0]  SEL_LAST = 2'd2;

    typedef struct packed {
        logic [1:0] size;
        logic [1:0] line;
        logic [1:0] assoc;
        logic       wp;
    } tune_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE, S_FLUSH, S_MEASURE, S_DECIDE, S_DONE
    } tune_state_t;

    typedef enum logic [1:0] {
        P_SIZE, P_LINE, P_ASSOC, P_WPRED
    } tune_phase_t;

    localparam tune_cfg_t CFG_INIT = '0;
endpackage

// File: rtl/tune_energy_acc.sv
module tune_energy_acc #(
    parameter int K_W   = 16,
    parameter int ACC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             hit,
    input  logic             miss,
    input  logic             tick,
    input  logic [K_W-1:0]   e_hit,
    input  logic [K_W-1:0]   k_miss,
    input  logic [K_W-1:0]   e_static,
    output logic [ACC_W-1:0] acc
);
    localparam int PROD_W = 2 * K_W;
    localparam int ADD_W  = PROD_W + 2;

    logic [PROD_W-1:0] e_miss;
    logic [ADD_W-1:0]  addend;
    logic [ACC_W:0]    sum;

    always_comb begin
        e_miss = PROD_W'(e_hit) * PROD_W'(k_miss);
        addend = (hit  ? ADD_W'(e_hit)    : '0)
               + (miss ? ADD_W'(e_miss)   : '0)
               + (tick ? ADD_W'(e_static) : '0);
        sum    = {1'b0, acc} + (ACC_W+1)'(addend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= '0;
        else if (en)  acc <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
    end

    // R4: saturating accumulation never wraps downward inside a window
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (acc >= $past(acc)));
endmodule

// File: rtl/tune_window_cnt.sv
module tune_window_cnt #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             tick,
    input  logic [WIN_W-1:0] window,
    output logic             last
);
    logic [WIN_W-1:0] cnt_q;
    logic [WIN_W:0]   nxt;

    always_comb begin
        nxt  = {1'b0, cnt_q} + (WIN_W+1)'(1);
        last = en && tick && (nxt >= {1'b0, window});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clr)         cnt_q <= '0;
        else if (en && tick)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cache_tune_ctrl.sv
module cache_tune_ctrl
    import tune_pkg::*;
#(
    parameter int K_W   = 16,
    parameter int ACC_W = 48,
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             hit_i,
    input  logic             miss_i,
    input  logic             tick_i,
    input  logic [K_W-1:0]   e_hit_i,
    input  logic [K_W-1:0]   k_miss_i,
    input  logic [K_W-1:0]   e_static_i,
    input  logic [WIN_W-1:0] window_i,
    input  logic             flush_done_i,
    output logic             flush_req_o,
    output logic [1:0]       size_sel_o,
    output logic [1:0]       line_sel_o,
    output logic [1:0]       assoc_sel_o,
    output logic             wpred_en_o,
    output logic             done_o
);
    tune_state_t      state_q, state_n;
    tune_phase_t      phase_q, phase_n;
    tune_cfg_t        cfg_q, cfg_n, best_q, best_n, nb;
    logic [ACC_W-1:0] best_e_q, best_e_n, energy;
    logic             first_q, first_n, final_q, final_n;
    logic             better, can_step, win_last, finish;

    tune_energy_acc #(.K_W(K_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == S_FLUSH), .en(state_q == S_MEASURE),
        .hit(hit_i), .miss(miss_i), .tick(tick_i),
        .e_hit(e_hit_i), .k_miss(k_miss_i), .e_static(e_static_i),
        .acc(energy)
    );

    tune_window_cnt #(.WIN_W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == S_FLUSH), .en(state_q == S_MEASURE),
        .tick(tick_i), .window(window_i), .last(win_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            phase_q  <= P_SIZE;
            cfg_q    <= CFG_INIT;
            best_q   <= CFG_INIT;
            best_e_q <= '1;
            first_q  <= 1'b0;
            final_q  <= 1'b0;
        end else begin
            state_q  <= state_n;
            phase_q  <= phase_n;
            cfg_q    <= cfg_n;
            best_q   <= best_n;
            best_e_q <= best_e_n;
            first_q  <= first_n;
            final_q  <= final_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n  = state_q;
        phase_n  = phase_q;
        cfg_n    = cfg_q;
        best_n   = best_q;
        best_e_n = best_e_q;
        first_n  = first_q;
        final_n  = final_q;
        better   = first_q || (energy < best_e_q);
        nb       = better ? cfg_q : best_q;
        can_step = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            S_IDLE, S_DONE: begin
                if (start_i) begin
                    state_n  = S_FLUSH;
                    phase_n  = P_SIZE;
                    cfg_n    = CFG_INIT;
                    best_n   = CFG_INIT;
                    best_e_n = '1;
                    first_n  = 1'b1;
                    final_n  = 1'b0;
                end
            end
            S_FLUSH: begin
                if (flush_done_i) state_n = final_q ? S_DONE : S_MEASURE;
            end
            S_MEASURE: begin
                if (win_last) state_n = S_DECIDE;
            end
            S_DECIDE: begin
                first_n = 1'b0;
                best_n  = nb;
                if (better) best_e_n = energy;
                unique case (phase_q)
                    P_SIZE:  can_step = better && (cfg_q.size  != SEL_LAST);
                    P_LINE:  can_step = better && (cfg_q.line  != SEL_LAST);
                    P_ASSOC: can_step = better && (cfg_q.assoc != SEL_LAST);
                    P_WPRED: can_step = 1'b0;
                endcase
                state_n = S_FLUSH;
                if (can_step) begin
                    unique case (phase_q)
                        P_SIZE:  cfg_n.size  = cfg_q.size  + 2'd1;
                        P_LINE:  cfg_n.line  = cfg_q.line  + 2'd1;
                        P_ASSOC: cfg_n.assoc = cfg_q.assoc + 2'd1;
                        P_WPRED: cfg_n.wp    = 1'b1;
                    endcase
                end else begin
                    cfg_n = nb;
                    unique case (phase_q)
                        P_SIZE:  begin phase_n = P_LINE;  cfg_n.line  = 2'd1; end
                        P_LINE:  begin phase_n = P_ASSOC; cfg_n.assoc = 2'd1; end
                        P_ASSOC: begin
                            if (nb.assoc != 2'd0) begin
                                phase_n  = P_WPRED;
                                cfg_n.wp = 1'b1;
                            end else begin
                                finish = 1'b1;
                            end
                        end
                        P_WPRED: finish = 1'b1;
                    endcase
                    if (finish) begin
                        if (nb != cfg_q) final_n = 1'b1;
                        else             state_n = S_DONE;
                    end
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        flush_req_o = (state_q == S_FLUSH);
        done_o      = (state_q == S_DONE);
        size_sel_o  = cfg_q.size;
        line_sel_o  = cfg_q.line;
        assoc_sel_o = cfg_q.assoc;
        wpred_en_o  = cfg_q.wp;
    end

    // R3: request held until acknowledged
    a_r3_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req_o && !flush_done_i) |=> flush_req_o);
    // R3: configuration frozen during measurement
    a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MEASURE) |=> $stable(cfg_q));
    // R7: no way prediction with direct mapping
    a_r7_wp_multiway: assert property (@(posedge clk) disable iff (!rst_n)
        wpred_en_o |-> (assoc_sel_o != 2'd0));
    // R1: only legal codes appear
    a_r1_legal_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel_o != 2'd3) && (line_sel_o != 2'd3) && (assoc_sel_o != 2'd3));
    // R9: result held until a new start
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(cfg_q)));
endmodule

// File: tb/test_cache_tune_ctrl.sv
`timescale 1ns/1ps
module test_cache_tune_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, hit_i = 1'b0, miss_i = 1'b0, tick_i = 1'b1;
    logic [15:0] e_hit_i = 16'd3, k_miss_i = 16'd5, e_static_i = 16'd2, window_i = 16'd64;
    logic        flush_done_i = 1'b0;
    logic        flush_req_o, wpred_en_o, done_o;
    logic [1:0]  size_sel_o, line_sel_o, assoc_sel_o;

    int n_checks = 0, n_fail = 0, flushes = 0, scen = 1, win = 64;
    bit summary_done = 0;

    always #10 clk = ~clk;

    cache_tune_ctrl i_cache_tune_ctrl (.*);

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int misses(input int sc, input int s, input int l, input int a, input int w);
        int sz[3] = '{12, 6, 9};
        int ln[3] = '{0, -3, 2};
        int as_[3] = '{0, 2, 2};
        if (sc == 2) return sz[s] + ln[l] + as_[a];
        if (sc == 4) return 40 - 6*s - 4*l - 3*a + 3*w;
        return 40 - 6*s - 4*l - 3*a - 2*w;
    endfunction

    // flush responder and traffic generator
    initial begin
        forever begin
            @(negedge clk);
            if (flush_req_o) begin
                logic [6:0] snap;
                int m;
                snap = {size_sel_o, line_sel_o, assoc_sel_o, wpred_en_o};
                flushes++;
                repeat (2) begin
                    @(negedge clk);
                    check("R3 request held", int'(flush_req_o), 1);
                end
                flush_done_i = 1'b1;
                @(negedge clk);
                flush_done_i = 1'b0;
                m = misses(scen, int'(snap[6:5]), int'(snap[4:3]), int'(snap[2:1]), int'(snap[0]));
                for (int i = 0; i < win; i++) begin
                    miss_i = (i < m);
                    hit_i  = !(i < m);
                    if (!done_o && {size_sel_o, line_sel_o, assoc_sel_o, wpred_en_o} != snap)
                        check("R3 cfg stable in window", 0, 1);
                    @(negedge clk);
                end
                hit_i = 1'b0; miss_i = 1'b0;
            end
        end
    end

    task automatic check_reset();
        @(negedge clk);
        check("R1 done", int'(done_o), 0);
        check("R1 flush_req", int'(flush_req_o), 0);
        check("R1 size", int'(size_sel_o), 0);
        check("R1 line", int'(line_sel_o), 0);
        check("R1 assoc", int'(assoc_sel_o), 0);
        check("R1 wpred", int'(wpred_en_o), 0);
    endtask

    task automatic run_scen(input int sc, input int k, input int w,
                            input int es, input int el, input int ea, input int ew, input int ef);
        int t = 0;
        scen = sc; win = w; k_miss_i = 16'(k); window_i = 16'(w);
        flushes = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check("R2 done low after start", int'(done_o), 0);
        check("R2 initial cfg", int'({size_sel_o, line_sel_o, assoc_sel_o, wpred_en_o}), 0);
        while (!done_o && t < 20000) begin @(negedge clk); t++; end
        check("R5 R6 size", int'(size_sel_o), es);
        check("R5 R6 line", int'(line_sel_o), el);
        check("R6 assoc", int'(assoc_sel_o), ea);
        check("R7 wpred", int'(wpred_en_o), ew);
        check("R8 flush count", flushes, ef);
        repeat (w + 6) @(negedge clk);
        check("R9 done held", int'(done_o), 1);
        check("R9 cfg held", int'({size_sel_o, line_sel_o, assoc_sel_o, wpred_en_o}),
              (es << 5) | (el << 3) | (ea << 1) | ew);
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        check_reset();
        // all parameters keep improving: largest everything, prediction on (R5, R8: 8 windows)
        run_scen(1, 5, 64, 2, 2, 2, 1, 8);
        // size peaks at 4 KB, line at 32 B, no assoc gain, prediction skipped (R6, R7, short window)
        run_scen(2, 5, 20, 1, 1, 0, 0, 7);
        // k_miss = 1 makes every config equal: ties do not advance (R4, R6)
        run_scen(3, 1, 64, 0, 0, 0, 0, 5);
        // prediction costs energy: reverted, final extra flush (R6, R7, R8)
        run_scen(4, 5, 64, 2, 2, 2, 0, 9);
        finish_run();
    end
endmodule